// File: doc/BRIEF.md
# Memory-to-Stream Source DMA Channel

This block is one source channel of a DMA engine. It fetches a programmed number of 32-bit words from memory through a simple request/response port and sends them out on a valid/ready stream. Software sets a 64-bit start address through two 32-bit registers. It then writes a size word that holds the word count and an end-of-message flag, and that write starts the transfer. While the channel runs, the address registers read back the next address to be requested and the size register reads back the number of words the stream has not yet accepted.

Two independent hold bits give software control over the transfer. One stops new memory requests. The other freezes the path from the internal FIFO to the stream. Clearing a hold bit continues the transfer exactly where it stopped. The channel keeps a running 32-bit additive checksum of every word returned by memory, and this sum carries over from one transfer to the next until software clears it. An optional byte reversal is applied to each word as it leaves on the stream. A busy flag covers the whole transfer, and a one-cycle done pulse marks its end.

Top module: `strm_src_dma`

## Requirements
- R1: Register index 2 is the size word: bits 31:2 give the word count and bit 0 is the end-of-message flag. Writing it while idle starts a transfer. `busy` is high from the next cycle until the cycle after the final word is accepted on the stream. In that cycle `busy` is low and `done` is high for exactly one cycle.
- R2: Writing a count of zero issues no memory request. `done` pulses in the next cycle and `busy` stays low.
- R3: Word k of a transfer is requested at address base+4k and leaves on the stream in request order. Bits 1:0 of a write to the low address register (index 0) are ignored. Index 1 holds address bits 63:32, and a carry out of bit 31 propagates into them.
- R4: When the end-of-message flag is set, `st_last` is high together with `st_valid` on the final word only. When the flag is clear, `st_last` is never high.
- R5: Reads of index 0 and index 1 return the running next-request address. A read of index 2 returns {words not yet accepted on the stream, 1'b0, flag}.
- R6: Control register (index 3) bit 0 is the memory hold. From the cycle after it is set, no request is issued. Responses to requests already issued are still taken. Clearing the bit resumes requests at the next address.
- R7: Control bit 1 is the stream hold. From the cycle after it is set, `st_valid` stays low and no FIFO word is lost. Clearing it resumes with the next word.
- R8: Index 4 reads the sum modulo 2^32 of every raw response word, accumulated across transfers. Any write to index 4 clears the sum. A clear in the same cycle as a response leaves that response word as the new sum.
- R9: Control bit 2 set reverses the byte order of each word on `st_data`. Cleared, words pass unchanged.
- R10: Requests outstanding plus FIFO occupancy never exceed the FIFO depth (16). A request is only raised when there is room for it.
- R11: Writes to index 0, 1 or 2 while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 64 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Response word valid, in request order |
| mem_rsp_data | input | 32 | Response word |
| st_valid | output | 1 | Stream word valid |
| st_ready | input | 1 | Stream sink accepts the word |
| st_data | output | 32 | Stream word, optionally byte reversed |
| st_last | output | 1 | Final word of a flagged transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A checksum clear can arrive in the same cycle as a memory response. The bench provokes this during a transfer by holding the clear write back until a cycle in which it is also driving a response. It then reads the sum after the transfer and compares it against a model in which that cycle's response word becomes the new sum. A second overlap, a FIFO push and a stream pop in one edge, comes up throughout the sweeps with irregular ready and response patterns. The bench judges it by the running size readback and by the exact word order on the stream.

// File: rtl/strm_src_pkg.sv
package strm_src_pkg;

    localparam int ADDR_W = 64;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 30;

    typedef enum logic [2:0] {
        RIDX_ADDR_LO = 3'd0,
        RIDX_ADDR_HI = 3'd1,
        RIDX_SIZE    = 3'd2,
        RIDX_CTRL    = 3'd3,
        RIDX_CSUM    = 3'd4
    } reg_idx_e;

    // control register, bit 2 down to bit 0
    typedef struct packed {
        logic flip;
        logic strm_hold;
        logic mem_hold;
    } ctrl_t;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W/8; b++) begin
            r[8*b +: 8] = w[8*(WORD_W/8-1-b) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/src_req_issue.sv
module src_req_issue
    import strm_src_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic              start,
    input  logic [CNT_W-1:0]  words,
    input  logic              hold,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              rsp_fire,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LVL_W-1:0]  outstanding
);
    localparam logic [LVL_W:0] LIMIT = (LVL_W+1)'(DEPTH);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [LVL_W-1:0]  out_q;
    logic              room;
    logic              fire;

    assign room      = ({1'b0, fifo_level} + {1'b0, out_q}) < LIMIT;
    assign req_valid = (left_q != '0) && !hold && room;
    assign fire      = req_valid && req_ready;
    assign req_addr  = addr_q;
    assign outstanding = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            left_q <= '0;
            out_q  <= '0;
        end else begin
            if (ld_lo) addr_q[31:0]  <= wdata;
            if (ld_hi) addr_q[63:32] <= wdata;
            if (start) begin
                left_q <= words;
            end else if (fire) begin
                left_q <= left_q - 1'b1;
                addr_q <= addr_q + 64'd4;
            end
            case ({fire, rsp_fire})
                2'b10:   out_q <= out_q + 1'b1;
                2'b01:   out_q <= out_q - 1'b1;
                default: out_q <= out_q;
            endcase
        end
    end
endmodule

// File: rtl/src_word_fifo.sv
module src_word_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             not_empty,
    output logic [LVL_W-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q;
    logic [PTR_W-1:0] rd_q;
    logic [LVL_W-1:0] lvl_q;

    assign head      = mem_q[rd_q];
    assign not_empty = (lvl_q != '0);
    assign level     = lvl_q;

    always_ff @(posedge clk) begin
        if (push) mem_q[wr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
            case ({push, pop})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end
endmodule

// File: rtl/src_stream_out.sv
module src_stream_out
    import strm_src_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  words,
    input  logic              eom,
    input  logic              fifo_has,
    input  logic [WORD_W-1:0] fifo_word,
    input  logic              hold,
    input  logic              flip,
    input  logic              st_ready,
    output logic              st_valid,
    output logic [WORD_W-1:0] st_data,
    output logic              st_last,
    output logic              pop,
    output logic [CNT_W-1:0]  left,
    output logic              eom_flag,
    output logic              active,
    output logic              done
);
    logic [CNT_W-1:0] left_q;
    logic             eom_q;
    logic             act_q;
    logic             done_q;
    logic             final_word;

    assign final_word = (left_q == CNT_W'(1));
    assign st_valid   = act_q && fifo_has && !hold;
    assign st_data    = flip ? swap_bytes(fifo_word) : fifo_word;
    assign st_last    = st_valid && eom_q && final_word;
    assign pop        = st_valid && st_ready;
    assign left       = left_q;
    assign eom_flag   = eom_q;
    assign active     = act_q;
    assign done       = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            eom_q  <= 1'b0;
            act_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                left_q <= words;
                eom_q  <= eom;
                act_q  <= (words != '0);
                done_q <= (words == '0);
            end else if (pop) begin
                left_q <= left_q - 1'b1;
                if (final_word) begin
                    act_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/src_csum.sv
module src_csum
    import strm_src_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] sum
);
    logic [WORD_W-1:0] sum_q;
    assign sum = sum_q;

    always_ff @(posedge clk) begin
        if (rst)      sum_q <= '0;
        else if (clr) sum_q <= add ? word : '0;
        else if (add) sum_q <= sum_q + word;
    end
endmodule

// File: rtl/strm_src_dma.sv
module strm_src_dma
    import strm_src_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_idx,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [63:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        st_valid,
    input  logic        st_ready,
    output logic [31:0] st_data,
    output logic        st_last,
    output logic        busy,
    output logic        done
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    ctrl_t            ctrl_q;
    logic             idle;
    logic             ld_lo, ld_hi, start, csum_clr;
    logic [31:0]      lo_data;
    logic [LVL_W-1:0] fifo_level;
    logic [LVL_W-1:0] outstanding;
    logic             fifo_has;
    logic [31:0]      fifo_word;
    logic             pop;
    logic [CNT_W-1:0] left;
    logic             eom_flag;
    logic             active;
    logic [31:0]      csum;
    logic             mem_hold_w;
    logic             strm_hold_w;

    assign idle     = !active;
    assign ld_lo    = reg_wr && idle && (reg_idx == RIDX_ADDR_LO);
    assign ld_hi    = reg_wr && idle && (reg_idx == RIDX_ADDR_HI);
    assign start    = reg_wr && idle && (reg_idx == RIDX_SIZE);
    assign csum_clr = reg_wr && (reg_idx == RIDX_CSUM);
    assign lo_data  = ld_lo ? {reg_wdata[31:2], 2'b00} : reg_wdata;
    assign mem_hold_w  = ctrl_q.mem_hold;
    assign strm_hold_w = ctrl_q.strm_hold;
    assign busy     = active;

    always_ff @(posedge clk) begin
        if (rst)                                     ctrl_q <= '0;
        else if (reg_wr && (reg_idx == RIDX_CTRL))   ctrl_q <= ctrl_t'(reg_wdata[2:0]);
    end

    src_req_issue #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_issue (
        .clk(clk), .rst(rst),
        .ld_lo(ld_lo), .ld_hi(ld_hi), .wdata(lo_data),
        .start(start), .words(reg_wdata[31:2]),
        .hold(mem_hold_w), .fifo_level(fifo_level), .rsp_fire(mem_rsp_valid),
        .req_ready(mem_req_ready), .req_valid(mem_req_valid),
        .req_addr(mem_req_addr), .outstanding(outstanding)
    );

    src_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W), .LVL_W(LVL_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push(mem_rsp_valid), .push_data(mem_rsp_data), .pop(pop),
        .head(fifo_word), .not_empty(fifo_has), .level(fifo_level)
    );

    src_stream_out u_out (
        .clk(clk), .rst(rst),
        .start(start), .words(reg_wdata[31:2]), .eom(reg_wdata[0]),
        .fifo_has(fifo_has), .fifo_word(fifo_word),
        .hold(strm_hold_w), .flip(ctrl_q.flip), .st_ready(st_ready),
        .st_valid(st_valid), .st_data(st_data), .st_last(st_last),
        .pop(pop), .left(left), .eom_flag(eom_flag),
        .active(active), .done(done)
    );

    src_csum u_csum (
        .clk(clk), .rst(rst),
        .clr(csum_clr), .add(mem_rsp_valid), .word(mem_rsp_data),
        .sum(csum)
    );

    always_comb begin
        case (reg_idx)
            RIDX_ADDR_LO: reg_rdata = mem_req_addr[31:0];
            RIDX_ADDR_HI: reg_rdata = mem_req_addr[63:32];
            RIDX_SIZE:    reg_rdata = {left, 1'b0, eom_flag};
            RIDX_CTRL:    reg_rdata = {29'd0, ctrl_q};
            RIDX_CSUM:    reg_rdata = csum;
            default:      reg_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/strm_src_dma_chk.sv
module strm_src_dma_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_hold,
    input logic             strm_hold,
    input logic             mem_req_valid,
    input logic             st_valid,
    input logic             busy,
    input logic             done,
    input logic [LVL_W-1:0] fifo_level,
    input logic [LVL_W-1:0] outstanding
);
    localparam logic [LVL_W:0] LIMIT = (LVL_W+1)'(DEPTH);

    assert_credit_R10: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, fifo_level} + {1'b0, outstanding}) <= LIMIT);

    assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_idle_no_req_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req_valid);

    assert_idle_no_stream_R7: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> busy);

    assert_mem_hold_R6: assert property (@(posedge clk) disable iff (rst)
        mem_hold |=> (outstanding <= $past(outstanding)));

    assert_strm_hold_R7: assert property (@(posedge clk) disable iff (rst)
        strm_hold |=> (fifo_level >= $past(fifo_level)));
endmodule

bind strm_src_dma strm_src_dma_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst),
    .mem_hold(mem_hold_w), .strm_hold(strm_hold_w),
    .mem_req_valid(mem_req_valid), .st_valid(st_valid),
    .busy(busy), .done(done),
    .fifo_level(fifo_level), .outstanding(outstanding)
);

// File: tb/strm_src_dma_tb.sv
module strm_src_dma_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [2:0]  reg_idx;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mem_req_valid, mem_req_ready;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        st_valid, st_ready, st_last, busy, done;
    logic [31:0] st_data;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic [63:0] q_addr [64];
    int q_head = 0;
    int q_tail = 0;
    logic [31:0] csum_exp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strm_src_dma u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .st_valid(st_valid), .st_ready(st_ready),
        .st_data(st_data), .st_last(st_last), .busy(busy), .done(done)
    );

    function automatic logic [31:0] mem_word(input logic [63:0] a);
        return a[31:0] * 32'h9E3779B1 + a[63:32] + 32'h13579BDF;
    endfunction

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic bit gate(input int m, input int c);
        return (m == 0) ? 1'b1 : ((c % m) != 0);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b0; reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    task automatic run_xfer(input logic [63:0] base, input int n, input bit eom, input bit flip,
                            input int rdy_m, input int st_m, input int rsp_m,
                            input int mp_on, input int mp_off, input int sp_on, input int sp_off,
                            input int clr_at, input int busy_wr_at);
        logic [63:0] base_al;
        logic [31:0] rd;
        bit mp, sp, clr_done, done_seen;
        int issued, acc, post;
        base_al = {base[63:2], 2'b00};
        mp = 0; sp = 0; clr_done = 0; done_seen = 0;
        issued = 0; acc = 0; post = 0;
        wr_reg(3'd3, {29'd0, flip, 2'b00});
        wr_reg(3'd0, base[31:0]);
        wr_reg(3'd1, base[63:32]);
        wr_reg(3'd2, {n[29:0], 1'b0, eom});
        for (int c = 0; c < 4000; c++) begin
            bit wr_now, clr_now, nmp, nsp, rsp_now;
            @(negedge clk);
            mem_req_ready = gate(rdy_m, c);
            st_ready      = gate(st_m, c);
            rsp_now       = (q_head != q_tail) && gate(rsp_m, c);
            mem_rsp_valid = rsp_now;
            mem_rsp_data  = rsp_now ? mem_word(q_addr[q_head % 64]) : 32'h0;
            nmp = mp; nsp = sp;
            if (c == mp_on) nmp = 1; if (c == mp_off) nmp = 0;
            if (c == sp_on) nsp = 1; if (c == sp_off) nsp = 0;
            wr_now = 0; clr_now = 0;
            reg_wr = 1'b0;
            reg_idx = (c % 2 == 1) ? 3'd0 : 3'd2;
            if (nmp != mp || nsp != sp) begin
                wr_now = 1; reg_wr = 1'b1; reg_idx = 3'd3; reg_wdata = {29'd0, flip, nsp, nmp};
            end else if (c >= clr_at && clr_at >= 0 && !clr_done && rsp_now) begin
                wr_now = 1; clr_now = 1; clr_done = 1;
                reg_wr = 1'b1; reg_idx = 3'd4; reg_wdata = 32'hFFFF_FFFF;
            end else if (c == busy_wr_at) begin
                // R11: size write during a transfer must be ignored
                wr_now = 1; reg_wr = 1'b1; reg_idx = 3'd2; reg_wdata = {30'd3, 2'b01};
            end
            #1;
            if (!done_seen) begin
                if (!wr_now && reg_idx == 3'd2)
                    chk(reg_rdata == {30'(n - acc), 1'b0, eom}, "R5 size readback", reg_rdata, {30'(n - acc), 1'b0, eom});
                if (!wr_now && reg_idx == 3'd0)
                    chk(reg_rdata == 32'(base_al + 64'(4*issued)), "R5 addr readback", reg_rdata, 32'(base_al + 64'(4*issued)));
                chk(busy == (acc < n), "R1 busy", busy, (acc < n));
            end
            if (mp) chk(!mem_req_valid, "R6 memory hold", mem_req_valid, 0);
            if (sp) chk(!st_valid, "R7 stream hold", st_valid, 0);
            if (done) begin
                chk(!done_seen, "R1 done single", done_seen, 0);
                chk(acc == n, "R1 done after last word", acc, n);
                chk(!busy, "R1 busy low with done", busy, 0);
                done_seen = 1;
            end
            if (mem_req_valid && mem_req_ready) begin
                chk(mem_req_addr == base_al + 64'(4*issued), "R3 request address", mem_req_addr, base_al + 64'(4*issued));
                chk((issued - acc) < 16, "R10 credit", issued - acc, 16);
                q_addr[q_tail % 64] = mem_req_addr;
                q_tail++;
                issued++;
            end
            if (clr_now) csum_exp = 32'h0;
            if (rsp_now) begin
                csum_exp = csum_exp + mem_rsp_data;
                q_head++;
            end
            if (st_valid && st_ready) begin
                logic [31:0] w;
                w = mem_word(base_al + 64'(4*acc));
                if (flip) w = rev(w);
                chk(st_data == w, flip ? "R9 flipped word" : "R3 stream word", st_data, w);
                chk(st_last == (eom && acc == n - 1), "R4 last flag", st_last, (eom && acc == n - 1));
                acc++;
            end
            mp = nmp; sp = nsp;
            if (done_seen) begin
                post++;
                if (post > 2) break;
            end
        end
        reg_wr = 1'b0;
        chk(done_seen, "R1 transfer completes", done_seen, 1);
        chk(issued == n, "R3 request count", issued, n);
        rd_reg(3'd4, rd);
        chk(rd == csum_exp, "R8 checksum", rd, csum_exp);
        rd_reg(3'd1, rd);
        chk(rd == 32'((base_al + 64'(4*n)) >> 32), "R3 high address", rd, 32'((base_al + 64'(4*n)) >> 32));
        rd_reg(3'd0, rd);
        chk(rd == 32'(base_al + 64'(4*n)), "R5 final address", rd, 32'(base_al + 64'(4*n)));
    endtask

    initial begin
        logic [31:0] rd;
        int ns [8];
        ns = '{1, 2, 3, 4, 7, 16, 17, 33};
        rst = 1'b1; reg_wr = 1'b0; reg_idx = 3'd0; reg_wdata = 32'h0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = 32'h0; st_ready = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        for (int i = 0; i < 5; i++) begin
            rd_reg(3'(i), rd);
            chk(rd == 32'h0, "R5 reset register", rd, 0);
        end
        chk(!busy && !done && !st_valid && !mem_req_valid, "R1 reset outputs",
            {busy, done, st_valid, mem_req_valid}, 0);

        // sweep over lengths and handshake patterns
        for (int i = 0; i < 8; i++) begin
            for (int p = 0; p < 3; p++) begin
                int rm, sm, pm;
                rm = (p == 0) ? 0 : (p == 1 ? 3 : 2);
                sm = (p == 0) ? 0 : (p == 1 ? 2 : 3);
                pm = (p == 0) ? 0 : (p == 1 ? 4 : 3);
                run_xfer(64'h0000_0000_1000_0000 + 64'(ns[i] * 256) + 64'(p), ns[i],
                         bit'((ns[i] + p) % 2), bit'(p == 2), rm, sm, pm,
                         -1, -1, -1, -1, -1, -1);
            end
        end

        // R6 memory hold mid transfer
        run_xfer(64'h0000_0000_2000_0000, 20, 1'b1, 1'b0, 0, 0, 2, 2, 30, -1, -1, -1, -1);
        // R7 stream hold long enough to fill the FIFO (R10)
        run_xfer(64'h0000_0000_3000_0000, 24, 1'b1, 1'b0, 0, 0, 0, -1, -1, 3, 40, -1, -1);
        // both holds overlapping
        run_xfer(64'h0000_0000_3400_0000, 30, 1'b0, 1'b1, 2, 0, 3, 5, 25, 10, 35, -1, -1);
        // R8 checksum clear coinciding with a response
        run_xfer(64'h0000_0000_4000_0000, 10, 1'b0, 1'b0, 0, 3, 0, -1, -1, -1, -1, 4, -1);
        // R11 write of size while busy
        run_xfer(64'h0000_0000_5000_0000, 12, 1'b1, 1'b0, 0, 2, 0, -1, -1, -1, -1, -1, 3);
        // R3 carry into the high address word
        run_xfer(64'h0000_0002_FFFF_FFF0, 8, 1'b1, 1'b1, 3, 0, 2, -1, -1, -1, -1, -1, -1);

        // R2 zero-length transfer
        wr_reg(3'd2, 32'h0000_0001);
        @(negedge clk); #1;
        chk(done == 1'b1, "R2 done on zero size", done, 1);
        chk(busy == 1'b0, "R2 busy stays low", busy, 0);
        chk(mem_req_valid == 1'b0, "R2 no request", mem_req_valid, 0);
        @(negedge clk); #1;
        chk(done == 1'b0, "R2 done one cycle", done, 0);
        chk(busy == 1'b0 && mem_req_valid == 1'b0, "R2 stays idle", {busy, mem_req_valid}, 0);

        // R8 plain clear
        wr_reg(3'd4, 32'h0);
        rd_reg(3'd4, rd);
        chk(rd == 32'h0, "R8 clear", rd, 0);

        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++; fails++;
            $display("FAIL watchdog R1 act=%0d exp=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule